// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel RGB-style display. Software programs the sync widths, porch lengths and active size through a small register port. It then sets two run bits, and the block scans frame after frame in the pixel clock domain. Each line runs through sync, back porch, active and front porch, in that order. Each frame steps through the same four phases, counted in lines.

Software can follow the scan without an interrupt. A status register reports the current vertical phase and whether the generator has stopped. A 32-bit frame identifier steps by one each time the scan enters the vertical sync phase. Together these two registers let a driver work out how many frames have started and how many have ended. A frame interrupt can be placed at the start of vertical sync or at the start of the front porch. It is held in a write-one-to-clear pending bit. A stop request takes effect only at the end of the frame in progress. A self-clearing soft reset returns the control state to idle.

Top module: `vid_timing_gen`

## Requirements
- R1: Horizontal fields are programmed as count minus one. Register 1 holds the back porch in bits [CW-1:0] and the front porch in bits [16+CW-1:16]. Register 3 bits [CW-1:0] hold the hsync width. Register 4 bits [CW-1:0] hold the active pixel count. Each field reads back as written.
- R2: Vertical fields are programmed as count minus one, in lines. Register 2 holds the back porch in bits [CW-1:0] and the front porch in the upper field. Register 3 upper field holds the vsync width. Register 4 upper field holds the active line count.
- R3: While running, every line is hsync, back porch, active pixels, front porch, and every frame is vsync lines, back porch lines, active lines, front porch lines. hsync and vsync are high during their sync phases. den is high only on active pixels of active lines. The first cycle after a start is the first cycle of a frame.
- R4: The scan runs only while register 0 bit 0 (video enable) and bit 1 (per-frame enable) are both set. With either one clear and the block stopped, hsync, vsync and den stay low.
- R5: Register 7 bits [1:0] report the vertical phase: 0 sync, 1 back porch, 2 active, 3 front porch. Bit 2 is 1 while stopped. When stopped, the phase reads 0.
- R6: Register 8 is a 32-bit frame identifier. It is zero after reset and steps by one, modulo 2^32, on every entry to the vertical sync phase, including the first frame after a start.
- R7: Register 5 bit 0 is the global interrupt enable and bit 1 is the frame interrupt enable. The pending bit is set only when both are set. Bit 2 selects the point: 0 for entry to vertical sync, 1 for entry to the vertical front porch.
- R8: Register 6 bit 0 is the pending bit, and the irq output equals it. Writing 1 clears it. Writing 0 has no effect. A new event in the same cycle as a clear leaves it set.
- R9: Clearing either run bit lets the current frame finish. The block stops at the frame boundary and raises the stopped bit. A frame boundary that the clear reaches in time ends the scan at that boundary.
- R10: Writing 1 to register 0 bit 2 starts a soft reset. That bit reads 1 for one cycle and then clears itself. The reset clears the run bits, the interrupt enables, the pending bit and the frame identifier, and it stops the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | AW | Register write address |
| wrData | input | 32 | Register write data |
| rdAddr | input | AW | Register read address |
| rdData | output | 32 | Register read data, combinational |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| den | output | 1 | Data enable, active high |
| irq | output | 1 | Frame interrupt, level of the pending bit |

## Verification
The assertions assume that register writes arrive as single-cycle strobes. They also assume that timing fields change only while the scan is stopped, so that line and frame lengths stay constant for a whole frame. The stimulus writes the porch, width and size registers only while the block is stopped. During a run, the only writes it makes are a stop request or a pending-clear, at most one per cycle, with the data bit drawn at random. Random timing values stay small so that each run covers several complete frames.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_e;

  localparam logic [3:0] A_CTRL    = 4'd0;
  localparam logic [3:0] A_HTIM    = 4'd1;
  localparam logic [3:0] A_VTIM    = 4'd2;
  localparam logic [3:0] A_SYNCW   = 4'd3;
  localparam logic [3:0] A_SIZE    = 4'd4;
  localparam logic [3:0] A_IRQCFG  = 4'd5;
  localparam logic [3:0] A_IRQPEND = 4'd6;
  localparam logic [3:0] A_STATUS  = 4'd7;
  localparam logic [3:0] A_FRAME   = 4'd8;

  localparam int HI_LSB = 16;

  // control -> datapath strobes
  typedef struct packed {
    logic runReq;
    logic clear;
  } vtg_cmd_t;

  // datapath -> control events
  typedef struct packed {
    logic syncEntry;
    logic frontEntry;
    logic running;
  } vtg_evt_t;
endpackage

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int AW = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [AW-1:0]       wrAddr,
  input  logic [31:0]         wrData,
  input  logic [AW-1:0]       rdAddr,
  output logic [31:0]         rdData,
  input  vtg_evt_t            evt,
  input  logic [31:0]         frameId,
  input  logic [1:0]          vPhase,
  output vtg_cmd_t            cmd,
  output logic [3:0][CW-1:0]  hLim,
  output logic [3:0][CW-1:0]  vLim,
  output logic                irq
);
  localparam int LO_W = CW;

  logic [CW-1:0] hBack, hFront, hSw, hAct;
  logic [CW-1:0] vBack, vFront, vSw, vAct;
  logic runEn, frameEn, busy;
  logic gIntEn, fIntEn, selFront, pend;
  logic irqEvent, pendClr;
  logic unusedOk;

  assign unusedOk = &{1'b0, wrData};

  assign hLim = {hFront, hAct, hBack, hSw};
  assign vLim = {vFront, vAct, vBack, vSw};

  assign cmd.runReq = runEn & frameEn & ~busy;
  assign cmd.clear  = busy;

  assign irqEvent = gIntEn & fIntEn & (selFront ? evt.frontEntry : evt.syncEntry);
  assign pendClr  = wrEn && (wrAddr == AW'(A_IRQPEND)) && wrData[0];
  assign irq      = pend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hBack <= '0; hFront <= '0; hSw <= '0; hAct <= '0;
      vBack <= '0; vFront <= '0; vSw <= '0; vAct <= '0;
      runEn <= 1'b0; frameEn <= 1'b0; busy <= 1'b0;
      gIntEn <= 1'b0; fIntEn <= 1'b0; selFront <= 1'b0; pend <= 1'b0;
    end else if (busy) begin
      busy     <= 1'b0;
      runEn    <= 1'b0;
      frameEn  <= 1'b0;
      gIntEn   <= 1'b0;
      fIntEn   <= 1'b0;
      selFront <= 1'b0;
      pend     <= 1'b0;
    end else begin
      if (wrEn) begin
        case (wrAddr)
          AW'(A_CTRL): begin
            runEn   <= wrData[0];
            frameEn <= wrData[1];
            busy    <= wrData[2];
          end
          AW'(A_HTIM): begin
            hBack  <= wrData[LO_W-1:0];
            hFront <= wrData[HI_LSB +: CW];
          end
          AW'(A_VTIM): begin
            vBack  <= wrData[LO_W-1:0];
            vFront <= wrData[HI_LSB +: CW];
          end
          AW'(A_SYNCW): begin
            hSw <= wrData[LO_W-1:0];
            vSw <= wrData[HI_LSB +: CW];
          end
          AW'(A_SIZE): begin
            hAct <= wrData[LO_W-1:0];
            vAct <= wrData[HI_LSB +: CW];
          end
          AW'(A_IRQCFG): begin
            gIntEn   <= wrData[0];
            fIntEn   <= wrData[1];
            selFront <= wrData[2];
          end
          default: ;
        endcase
      end
      pend <= irqEvent | (pend & ~pendClr);
    end
  end

  always_comb begin
    case (rdAddr)
      AW'(A_CTRL):    rdData = {29'd0, busy, frameEn, runEn};
      AW'(A_HTIM):    rdData = 32'(hBack) | (32'(hFront) << HI_LSB);
      AW'(A_VTIM):    rdData = 32'(vBack) | (32'(vFront) << HI_LSB);
      AW'(A_SYNCW):   rdData = 32'(hSw)   | (32'(vSw)    << HI_LSB);
      AW'(A_SIZE):    rdData = 32'(hAct)  | (32'(vAct)   << HI_LSB);
      AW'(A_IRQCFG):  rdData = {29'd0, selFront, fIntEn, gIntEn};
      AW'(A_IRQPEND): rdData = {31'd0, pend};
      AW'(A_STATUS):  rdData = {29'd0, ~evt.running, vPhase};
      AW'(A_FRAME):   rdData = frameId;
      default:        rdData = '0;
    endcase
  end
endmodule

// File: rtl/vtg_datapath.sv
module vtg_datapath
  import vtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  vtg_cmd_t           cmd,
  input  logic [3:0][CW-1:0] hLim,
  input  logic [3:0][CW-1:0] vLim,
  output vtg_evt_t           evt,
  output logic [31:0]        frameId,
  output logic [1:0]         vPhase,
  output logic               hsync,
  output logic               vsync,
  output logic               den
);
  phase_e        hPh, vPh;
  logic [CW-1:0] hCnt, vCnt;
  logic          running;
  logic [31:0]   frameCnt;
  logic          hPhEnd, vPhEnd, lineEnd, frameEnd;
  logic          startFrame, haltFrame;

  assign hPhEnd   = (hCnt == hLim[hPh]);
  assign vPhEnd   = (vCnt == vLim[vPh]);
  assign lineEnd  = (hPh == PH_FRONT) && hPhEnd;
  assign frameEnd = lineEnd && (vPh == PH_FRONT) && vPhEnd;

  assign startFrame = !cmd.clear && cmd.runReq && (!running || frameEnd);
  assign haltFrame  = !cmd.clear && running && frameEnd && !cmd.runReq;

  assign evt.syncEntry  = startFrame;
  assign evt.frontEntry = !cmd.clear && running && lineEnd && (vPh == PH_ACT) && vPhEnd;
  assign evt.running    = running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPh <= PH_SYNC; vPh <= PH_SYNC;
      hCnt <= '0; vCnt <= '0;
      running <= 1'b0; frameCnt <= '0;
    end else if (cmd.clear) begin
      hPh <= PH_SYNC; vPh <= PH_SYNC;
      hCnt <= '0; vCnt <= '0;
      running <= 1'b0; frameCnt <= '0;
    end else if (startFrame || haltFrame || !running) begin
      hPh <= PH_SYNC; vPh <= PH_SYNC;
      hCnt <= '0; vCnt <= '0;
      running <= startFrame;
      if (startFrame) frameCnt <= frameCnt + 32'd1;
    end else begin
      if (hPhEnd) begin
        hCnt <= '0;
        hPh  <= phase_e'(hPh + 2'd1);
      end else begin
        hCnt <= hCnt + 1'b1;
      end
      if (lineEnd) begin
        if (vPhEnd) begin
          vCnt <= '0;
          vPh  <= phase_e'(vPh + 2'd1);
        end else begin
          vCnt <= vCnt + 1'b1;
        end
      end
    end
  end

  assign frameId = frameCnt;
  assign vPhase  = vPh;
  assign hsync   = running && (hPh == PH_SYNC);
  assign vsync   = running && (vPh == PH_SYNC);
  assign den     = running && (hPh == PH_ACT) && (vPh == PH_ACT);
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [31:0]   wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [31:0]   rdData,
  output logic          hsync,
  output logic          vsync,
  output logic          den,
  output logic          irq
);
  vtg_cmd_t           cmdBus;
  vtg_evt_t           evtBus;
  logic [3:0][CW-1:0] hLim, vLim;
  logic [31:0]        frameId;
  logic [1:0]         vPhase;
  logic               isRunning, clearing;

  assign isRunning = evtBus.running;
  assign clearing  = cmdBus.clear;

  vtg_ctrl #(.CW(CW), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .evt(evtBus), .frameId(frameId), .vPhase(vPhase),
    .cmd(cmdBus), .hLim(hLim), .vLim(vLim), .irq(irq)
  );

  vtg_datapath #(.CW(CW)) u_dp (
    .clk(clk), .rstN(rstN),
    .cmd(cmdBus), .hLim(hLim), .vLim(vLim),
    .evt(evtBus), .frameId(frameId), .vPhase(vPhase),
    .hsync(hsync), .vsync(vsync), .den(den)
  );
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker
  import vtg_pkg::*;
#(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic [AW-1:0] wrAddr,
  input logic [31:0]   wrData,
  input logic          hsync,
  input logic          vsync,
  input logic          den,
  input logic          irq,
  input logic          isRunning,
  input logic          clearing,
  input logic [31:0]   frameId
);
  p_den_blank_r3: assert property (@(posedge clk) disable iff (!rstN)
    den |-> (!hsync && !vsync));

  p_start_sync_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isRunning) |-> (hsync && vsync));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !isRunning |-> (!hsync && !vsync && !den));

  p_frame_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (frameId != $past(frameId)) |-> ((frameId == $past(frameId) + 32'd1) || (frameId == 32'd0)));

  p_start_counts_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isRunning) |-> (frameId == $past(frameId) + 32'd1));

  p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(wrEn && wrAddr == AW'(A_IRQPEND) && wrData[0]) && !clearing) |=> irq);

  p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rstN)
    clearing |=> (frameId == 32'd0 && !irq && !isRunning && !clearing));
endmodule

bind vid_timing_gen vtg_checker #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN),
  .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .hsync(hsync), .vsync(vsync), .den(den), .irq(irq),
  .isRunning(isRunning), .clearing(clearing), .frameId(frameId)
);

// File: tb/sim_vid_timing_gen.sv
module sim_vid_timing_gen;
  import vtg_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        hsync, vsync, den, irq;

  int nChk = 0;
  int nErr = 0;
  int hs, hb, ha, hf, vs, vb, va, vf;
  int unsigned baseId = 0;

  vid_timing_gen u0 (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .hsync(hsync), .vsync(vsync), .den(den), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int hTot();
    return hs + hb + ha + hf + 4;
  endfunction

  function automatic int vTot();
    return vs + vb + va + vf + 4;
  endfunction

  // {den, vsync, hsync, vph[1:0]} at offset p inside a frame
  function automatic logic [4:0] expAt(input int p);
    int h, ln, px;
    logic [4:0] r;
    h = hTot(); ln = p / h; px = p % h;
    r[2] = (px < hs + 1);
    r[3] = (ln < vs + 1);
    r[4] = (px >= hs + hb + 2) && (px < hs + hb + ha + 3) &&
           (ln >= vs + vb + 2) && (ln < vs + vb + va + 3);
    if (ln < vs + 1)                r[1:0] = 2'd0;
    else if (ln < vs + vb + 2)      r[1:0] = 2'd1;
    else if (ln < vs + vb + va + 3) r[1:0] = 2'd2;
    else                            r[1:0] = 2'd3;
    return r;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic prog();
    logic [31:0] d;
    wr(A_HTIM,  32'(hb) | (32'(hf) << 16));
    wr(A_VTIM,  32'(vb) | (32'(vf) << 16));
    wr(A_SYNCW, 32'(hs) | (32'(vs) << 16));
    wr(A_SIZE,  32'(ha) | (32'(va) << 16));
    rd(A_HTIM, d);
    chk("R1 horizontal porch fields", d, 32'(hb) | (32'(hf) << 16));
    rd(A_SIZE, d);
    chk("R1 R2 size fields", d, 32'(ha) | (32'(va) << 16));
  endtask

  // start, check every cycle against the model, stop after disAt
  task automatic runChk(input int disAt, input logic [2:0] cfg);
    int f, nCyc, stopAt, fpOff;
    logic expPend, clrNext, isStat, intOn;
    f = hTot() * vTot();
    fpOff = (vs + vb + va + 3) * hTot();
    nCyc = disAt + 2 * f + 4;
    stopAt = 1 << 30;
    expPend = 1'b0; clrNext = 1'b0; isStat = 1'b1;
    intOn = cfg[0] & cfg[1];
    wr(A_IRQCFG, {29'd0, cfg});
    wr(A_IRQPEND, 32'd1);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = A_CTRL; wrData = 32'd3; rdAddr = A_STATUS;
    @(negedge clk);
    wrEn = 1'b0;
    for (int k = 0; k < nCyc; k++) begin
      logic run, ev;
      logic [4:0] e;
      int unsigned expId;
      @(negedge clk);
      run = (k < stopAt);
      e = run ? expAt(k % f) : 5'd0;
      expId = baseId + (run ? 32'(1 + k / f) : 32'(stopAt / f));
      ev = run && (cfg[2] ? (k % f == fpOff) : (k % f == 0));
      if (clrNext) expPend = 1'b0;
      if (intOn && ev) expPend = 1'b1;
      clrNext = 1'b0;
      chk("R1 R3 hsync", {31'd0, hsync}, {31'd0, e[2]});
      chk("R2 R3 vsync", {31'd0, vsync}, {31'd0, e[3]});
      chk("R1 R2 R3 den", {31'd0, den}, {31'd0, e[4]});
      chk("R7 R8 irq", {31'd0, irq}, {31'd0, expPend});
      if (isStat) chk("R5 R9 status", rdData, {29'd0, ~run, e[1:0]});
      else        chk("R6 frame id", rdData, expId);
      wrEn = 1'b0;
      isStat = !isStat;
      rdAddr = isStat ? A_STATUS : A_FRAME;
      if (k == disAt) begin
        wrEn = 1'b1; wrAddr = A_CTRL; wrData = 32'd0;
        stopAt = ((k + 2 + f - 1) / f) * f;
      end else if (($urandom % 5) == 0) begin
        wrEn = 1'b1; wrAddr = A_IRQPEND;
        wrData = {31'd0, 1'($urandom % 2)};
        clrNext = wrData[0];
      end
    end
    @(negedge clk);
    wrEn = 1'b0;
    baseId = baseId + 32'(stopAt / f);
  endtask

  task automatic quietRun(input logic [31:0] ctl);
    logic [31:0] d;
    wr(A_CTRL, ctl);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      chk("R4 no output with one enable", {29'd0, hsync, vsync, den}, 32'd0);
    end
    rd(A_STATUS, d);
    chk("R4 R5 still stopped", d, 32'd4);
    wr(A_CTRL, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nErr++; nChk++;
    $display("FAIL watchdog all requirements: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chk("R3 R4 outputs after reset", {28'd0, hsync, vsync, den, irq}, 32'd0);
    rd(A_FRAME, d);  chk("R6 frame id after reset", d, 32'd0);
    rd(A_STATUS, d); chk("R5 status after reset", d, 32'd4);
    rd(A_CTRL, d);   chk("R10 control after reset", d, 32'd0);

    hs = 1; hb = 2; ha = 3; hf = 1; vs = 0; vb = 1; va = 2; vf = 1;
    prog();
    quietRun(32'd1);
    quietRun(32'd2);

    runChk(5, 3'b011);                       // sync-entry interrupt
    runChk(hTot() * vTot() - 2, 3'b111);     // front-porch interrupt, stop lands on first boundary
    runChk(hTot() * vTot() - 1, 3'b010);     // global enable off; stop misses first boundary
    runChk(3, 3'b101);                       // frame enable off

    hs = 0; hb = 0; ha = 0; hf = 0; vs = 0; vb = 0; va = 0; vf = 0;
    prog();
    runChk(0, 3'b011);                       // minimum timing, stop at once

    for (int it = 0; it < 6; it++) begin
      hs = $urandom % 5; hb = $urandom % 5; ha = $urandom % 7; hf = $urandom % 5;
      vs = $urandom % 5; vb = $urandom % 5; va = $urandom % 5; vf = $urandom % 5;
      prog();
      runChk($urandom % (2 * hTot() * vTot()), 3'($urandom % 8));
    end

    // soft reset while running with a pending interrupt
    wr(A_IRQCFG, 32'd3);
    wr(A_CTRL, 32'd3);
    repeat (30) @(negedge clk);
    chk("R7 pending before soft reset", {31'd0, irq}, 32'd1);
    wrEn = 1'b1; wrAddr = A_CTRL; wrData = 32'd4;
    @(negedge clk);
    wrEn = 1'b0;
    rd(A_CTRL, d); chk("R10 reset bit reads set", d, 32'd4);
    @(negedge clk);
    rd(A_CTRL, d);   chk("R10 reset bit self-clears", d, 32'd0);
    rd(A_FRAME, d);  chk("R10 frame id cleared", d, 32'd0);
    rd(A_IRQCFG, d); chk("R10 interrupt enables cleared", d, 32'd0);
    rd(A_STATUS, d); chk("R10 scan stopped", d, 32'd4);
    chk("R10 outputs low", {28'd0, hsync, vsync, den, irq}, 32'd0);

    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule